// File: doc/BRIEF.md
# External Interrupt Request Flag Bank

This block holds one pending-request flag for each of sixteen external interrupt lines. Each line has its own 2-bit sense selection. The four choices are a low level on the pin, a high-to-low transition, a low-to-high transition, or either transition. Every pin passes through a two-flop synchroniser. Transitions are found by comparing the synchronised sample with the sample from the previous cycle. A flag sets in the cycle after its selected condition is seen on the synchronised level.

A flag is cleared in three ways:

- **Software clear.** Software clears a flag with a read-then-write sequence. The write of 0 to a bit clears it only if an earlier register read returned that bit as 1. Any write disarms the bit again.
- **Service acknowledge.** An acknowledge strobe clears the flag when the interrupt for that line is serviced. For a line in low-level mode, the clear applies only if the synchronised pin is already back high.
- **Transfer acknowledge.** A transfer-engine acknowledge clears the flag when that line's transfer-disable qualifier is 0.

When a set and a clear reach the same flag in the same cycle, the set wins, so no request is lost.

Top module: `irqf_status_reg`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `flags_o` and `reg_rdata` are all zero.
- R2: With sense code 00 (low level), a flag sets while its synchronised pin is low. A pin driven low before clock edge k shows in `flags_o` after edge k+2 and not before.
- R3: Sense code 01 sets the flag on a falling edge, 10 on a rising edge, and 11 on either edge. The same three-edge latency as R2 applies. A transition in the unselected direction leaves the flag clear.
- R4: A register write never sets a flag. Writing 1 to any bit leaves that bit unchanged.
- R5: A write with bit n = 0 clears flag n only if a read since the last write returned bit n as 1. Any write disarms every bit, so a second write of 0 with no new read has no effect.
- R6: In edge modes (codes 01, 10, 11), `svc_ack[n]` clears flag n at the next edge.
- R7: In low-level mode, `svc_ack[n]` clears flag n only when the synchronised pin n is high. While the pin is low, the flag stays set.
- R8: `xfer_ack[n]` with `xfer_dis[n]` = 0 clears flag n. With `xfer_dis[n]` = 1 it has no effect.
- R9: When a set event and any clear reach the same flag in the same cycle, the flag is 1 afterwards.
- R10: A read loads `reg_rdata` with the flags as they stood at that edge, bit n holding line n (bit 15 is the MSB). Without a read, `reg_rdata` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin | input | 16 | Asynchronous interrupt pins, idle high |
| sense_sel | input | 32 | Sense code per line, line n in bits [2n+1:2n] |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data; a 0 bit requests a clear |
| reg_rdata | output | 16 | Registered read data |
| svc_ack | input | 16 | Per-line service acknowledge |
| xfer_ack | input | 16 | Per-line transfer acknowledge |
| xfer_dis | input | 16 | Per-line transfer-disable qualifier |
| flags_o | output | 16 | Current flag state |

## Verification
Two functions can land on the same edge: a line's detected edge event and a clear of the same flag. The bench provokes this by driving a pin transition on a both-edge line whose flag is already set. Two edges later it raises service and transfer acknowledges together, so all three arrive in the cycle the event is seen. The flag must read 1 afterwards. A checker property also requires every flag that saw a set event in the previous cycle to be 1, whatever clears were pending.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  localparam int unsigned SENSE_W = 2;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= {W{IDLE}};
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/irqf_detect.sv
module irqf_detect
  import irqf_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         lvl,
  input  logic [N*SENSE_W-1:0] sense,
  output logic [N-1:0]         set_evt
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '1;
    else     prev_q <= lvl;
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    sense_e mode;
    logic   fell, rose;
    assign mode = sense_e'(sense[g*SENSE_W +: SENSE_W]);
    assign fell = prev_q[g] & ~lvl[g];
    assign rose = ~prev_q[g] & lvl[g];
    always_comb begin
      unique case (mode)
        SENSE_LOW:  set_evt[g] = ~lvl[g];
        SENSE_FALL: set_evt[g] = fell;
        SENSE_RISE: set_evt[g] = rose;
        default:    set_evt[g] = fell | rose;
      endcase
    end
  end
endmodule

// File: rtl/irqf_clear_ctl.sv
module irqf_clear_ctl
  import irqf_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0]         lvl,
  input  logic [N*SENSE_W-1:0] sense,
  input  logic [N-1:0]         svc_ack,
  input  logic [N-1:0]         xfer_ack,
  input  logic [N-1:0]         xfer_dis,
  output logic [N-1:0]         hw_clr
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic level_mode;
    logic svc_ok;
    assign level_mode = (sense_e'(sense[g*SENSE_W +: SENSE_W]) == SENSE_LOW);
    assign svc_ok     = svc_ack[g] & (~level_mode | lvl[g]);
    assign hw_clr[g]  = svc_ok | (xfer_ack[g] & ~xfer_dis[g]);
  end
endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] hw_clr,
  input  logic         reg_rd,
  input  logic         reg_wr,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q, arm_q, rdata_q, sw_clr;

  assign sw_clr = reg_wr ? (arm_q & ~reg_wdata) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      arm_q   <= '0;
      rdata_q <= '0;
    end else begin
      flag_q <= set_evt | (flag_q & ~(sw_clr | hw_clr));
      if (reg_wr)      arm_q <= '0;
      else if (reg_rd) arm_q <= arm_q | flag_q;
      if (reg_rd) rdata_q <= flag_q;
    end
  end

  assign flags     = flag_q;
  assign reg_rdata = rdata_q;
endmodule

// File: rtl/irqf_status_reg.sv
module irqf_status_reg
  import irqf_pkg::*;
#(
  parameter int unsigned N         = 16,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         irq_pin,
  input  logic [N*SENSE_W-1:0] sense_sel,
  input  logic                 reg_rd,
  input  logic                 reg_wr,
  input  logic [N-1:0]         reg_wdata,
  output logic [N-1:0]         reg_rdata,
  input  logic [N-1:0]         svc_ack,
  input  logic [N-1:0]         xfer_ack,
  input  logic [N-1:0]         xfer_dis,
  output logic [N-1:0]         flags_o
);
  logic [N-1:0] sync_lvl, set_evt, hw_clr;

  irqf_sync #(.W(N), .STAGES(SYNC_STGS), .IDLE(1'b1)) sync_i (
    .clk(clk), .rst(rst), .din(irq_pin), .dout(sync_lvl)
  );

  irqf_detect #(.N(N)) detect_i (
    .clk(clk), .rst(rst), .lvl(sync_lvl), .sense(sense_sel), .set_evt(set_evt)
  );

  irqf_clear_ctl #(.N(N)) clear_i (
    .lvl(sync_lvl), .sense(sense_sel), .svc_ack(svc_ack),
    .xfer_ack(xfer_ack), .xfer_dis(xfer_dis), .hw_clr(hw_clr)
  );

  irqf_flag_bank #(.N(N)) bank_i (
    .clk(clk), .rst(rst), .set_evt(set_evt), .hw_clr(hw_clr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .flags(flags_o)
  );
endmodule

// File: rtl/irqf_status_chk.sv
module irqf_status_chk #(
  parameter int unsigned N = 16
) (
  input logic           clk,
  input logic           rst,
  input logic [N-1:0]   flags_o,
  input logic [N-1:0]   reg_rdata,
  input logic           reg_rd,
  input logic           reg_wr,
  input logic [N-1:0]   reg_wdata,
  input logic [N-1:0]   svc_ack,
  input logic [N-1:0]   xfer_ack,
  input logic [N-1:0]   xfer_dis,
  input logic [N-1:0]   set_evt,
  input logic [N-1:0]   sync_lvl,
  input logic [2*N-1:0] sense_sel
);
  logic [N-1:0] low_hold;
  logic [N-1:0] any_hw;
  logic [N-1:0] wr_zero;

  always_comb begin
    for (int i = 0; i < N; i++)
      low_hold[i] = (sense_sel[2*i +: 2] == 2'b00) && !sync_lvl[i];
  end
  assign any_hw  = svc_ack | (xfer_ack & ~xfer_dis);
  assign wr_zero = reg_wr ? ~reg_wdata : '0;

  p_reset_zero_r1: assert property (@(posedge clk)
    $past(rst) |-> (flags_o == '0 && reg_rdata == '0));

  p_no_spurious_set_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((flags_o & ~$past(flags_o) & ~$past(set_evt)) == '0));

  p_clear_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~flags_o & $past(flags_o) & ~$past(any_hw) & ~$past(wr_zero)) == '0));

  p_level_holds_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~flags_o & $past(flags_o & svc_ack & low_hold)) == '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((~flags_o & $past(set_evt)) == '0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_rd)) |-> $stable(reg_rdata));
endmodule

bind irqf_status_reg irqf_status_chk #(.N(N)) chk_i (
  .clk(clk), .rst(rst), .flags_o(flags_o), .reg_rdata(reg_rdata),
  .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .svc_ack(svc_ack), .xfer_ack(xfer_ack), .xfer_dis(xfer_dis),
  .set_evt(set_evt), .sync_lvl(sync_lvl), .sense_sel(sense_sel)
);

// File: tb/irqf_status_reg_tb.sv
module irqf_status_reg_tb_top;
  localparam int N = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   irq_pin = '1;
  logic [2*N-1:0] sense_sel = {N{2'b01}};
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata, flags_o;
  logic [N-1:0] svc_ack = '0, xfer_ack = '0, xfer_dis = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqf_status_reg dut_i (
    .clk(clk), .rst(rst), .irq_pin(irq_pin), .sense_sel(sense_sel),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .svc_ack(svc_ack), .xfer_ack(xfer_ack),
    .xfer_dis(xfer_dis), .flags_o(flags_o)
  );

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input int line, input logic [1:0] code);
    sense_sel[2*line +: 2] = code;
  endtask

  task automatic svc_pulse(input int line);
    svc_ack[line] = 1'b1; tick(); svc_ack[line] = 1'b0;
  endtask

  task automatic do_read();
    reg_rd = 1'b1; tick(); reg_rd = 1'b0;
  endtask

  task automatic do_write(input logic [N-1:0] d);
    reg_wdata = d; reg_wr = 1'b1; tick(); reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 flags in reset", flags_o, '0);
    check("R1 rdata in reset", reg_rdata, '0);
    rst = 1'b0; tick();
    check("R1 flags after reset", flags_o, '0);
  endtask

  task automatic t_level();
    set_mode(3, 2'b00); tick(4);
    check("R2 no set while pin high", flags_o, '0);
    irq_pin[3] = 1'b0; tick(2);
    check("R2 not yet visible", flags_o, '0);
    tick();
    check("R2 low level sets", flags_o, 16'h0008);
    svc_pulse(3);
    check("R7 service with pin low keeps flag", flags_o, 16'h0008);
    irq_pin[3] = 1'b1; tick(4);
    check("R7 flag held until service", flags_o, 16'h0008);
    svc_pulse(3);
    check("R7 service with pin high clears", flags_o, '0);
    set_mode(3, 2'b01); tick(2);
  endtask

  task automatic t_edges();
    irq_pin[5] = 1'b0; tick(3);
    check("R3 falling edge sets", flags_o, 16'h0020);
    svc_pulse(5);
    check("R6 service clears falling-mode flag", flags_o, '0);
    irq_pin[5] = 1'b1; tick(4);
    check("R3 rise ignored in falling mode", flags_o, '0);
    set_mode(6, 2'b10); irq_pin[6] = 1'b0; tick(4);
    check("R3 fall ignored in rising mode", flags_o, '0);
    irq_pin[6] = 1'b1; tick(3);
    check("R3 rising edge sets", flags_o, 16'h0040);
    svc_pulse(6);
    check("R6 service clears rising-mode flag", flags_o, '0);
    set_mode(7, 2'b11); irq_pin[7] = 1'b0; tick(3);
    check("R3 both mode fall sets", flags_o, 16'h0080);
    svc_pulse(7);
    check("R6 service clears both-mode flag", flags_o, '0);
    irq_pin[7] = 1'b1; tick(3);
    check("R3 both mode rise sets", flags_o, 16'h0080);
    svc_pulse(7);
    set_mode(6, 2'b01); set_mode(7, 2'b01); tick(2);
  endtask

  task automatic t_sw_clear();
    do_read();
    irq_pin[5] = 1'b0; irq_pin[9] = 1'b0; tick(3);
    check("R5 setup flags", flags_o, 16'h0220);
    do_write('0);
    check("R5 write without armed read keeps flags", flags_o, 16'h0220);
    do_read();
    check("R10 read returns flags by bit", reg_rdata, 16'h0220);
    tick(2);
    check("R10 rdata holds without read", reg_rdata, 16'h0220);
    do_write(~16'h0020);
    check("R5 armed write of 0 clears only that bit", flags_o, 16'h0200);
    do_write('0);
    check("R5 write disarms all bits", flags_o, 16'h0200);
    do_read();
    do_write('0);
    check("R5 re-armed clear", flags_o, '0);
    irq_pin[5] = 1'b1; irq_pin[9] = 1'b1; tick(4);
  endtask

  task automatic t_write_ones();
    do_write('1);
    check("R4 writing ones sets nothing", flags_o, '0);
    irq_pin[12] = 1'b0; tick(3);
    do_read();
    do_write('1);
    check("R4 armed write of 1 keeps flag", flags_o, 16'h1000);
    svc_pulse(12);
    irq_pin[12] = 1'b1; tick(4);
    check("R4 cleanup", flags_o, '0);
  endtask

  task automatic t_xfer();
    irq_pin[2] = 1'b0; tick(3);
    xfer_dis[2] = 1'b1; xfer_ack[2] = 1'b1; tick();
    xfer_ack[2] = 1'b0; xfer_dis[2] = 1'b0;
    check("R8 disabled transfer ack ignored", flags_o, 16'h0004);
    xfer_ack[2] = 1'b1; tick(); xfer_ack[2] = 1'b0;
    check("R8 transfer ack clears", flags_o, '0);
    irq_pin[2] = 1'b1; tick(4);
  endtask

  task automatic t_set_wins();
    set_mode(10, 2'b11); irq_pin[10] = 1'b0; tick(3);
    check("R9 setup", flags_o, 16'h0400);
    irq_pin[10] = 1'b1; tick(2);
    svc_ack[10] = 1'b1; xfer_ack[10] = 1'b1; tick();
    svc_ack[10] = 1'b0; xfer_ack[10] = 1'b0;
    check("R9 set wins over clear", flags_o, 16'h0400);
    svc_pulse(10);
    check("R9 later clear works", flags_o, '0);
  endtask

  initial begin
    tick(4);
    t_reset();
    t_level();
    t_edges();
    t_sw_clear();
    t_write_ones();
    t_xfer();
    t_set_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule